// File: doc/BRIEF.md
# Multi-Channel Interrupt Vector Controller

This block gathers interrupt requests from a multi-channel packet engine and turns them into one level interrupt line for a host processor. Each of the transmit and receive channels raises a single-cycle completion request. Two error sources, a host error and a status event, do the same. Every request sets a sticky pending flag. A pending flag reaches the line and the vector only while its enable bit is set. Enable bits are changed through separate set and clear registers, so software never has to read, modify and write them back.

The host reads one vector word. It tells whether a transmit or a receive completion is waiting, which channel each one belongs to, and whether either error source is active. The host acknowledges channel flags through acknowledge registers that take a bit mask. The line stays asserted until an explicit end-of-interrupt write. After that write, it asserts again if an enabled source is still active. Registers are reached through a word-addressed port: writes are single-cycle strobes and reads are combinational.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `tx_req` or `rx_req` sets pending flag i of that group. The flag stays set after the pulse ends, until it is acknowledged.
- R2: Writing a mask to address 0x0 (transmit), 0x2 (receive) or 0x4 (error) sets the enable bits that are 1 in the mask. Writing a mask to address 0x1, 0x3 or 0x5 clears those bits, and a mask of 0xFF clears every channel. Reading addresses 0x0, 0x2 and 0x4 returns the current enables. Reads of addresses that are not decoded return 0.
- R3: A pending flag whose enable is clear does not appear in the vector and does not raise the line. Setting the enable later makes it appear.
- R4: The vector, read at address 0x6, has bit 16 set when any enabled transmit flag is pending. That channel number is in bits 2:0.
- R5: The vector has bit 17 set when any enabled receive flag is pending. That channel number is in bits 10:8.
- R6: Vector bit 18 reports a pending host error and bit 19 a pending status event. Each is gated by a 2-bit error enable: bit 0 for host error, bit 1 for status.
- R7: When several channels of a group are active, the vector reports the lowest-numbered one.
- R8: The line asserts on the cycle after any enabled source becomes active. It then stays asserted until an end-of-interrupt write, even if every source is acknowledged first.
- R9: A write of any data to address 0x7 drops the line for one cycle. The line asserts again on the next cycle if an enabled source is still active.
- R10: Writing a mask to address 0x8 (transmit), 0x9 (receive) or 0xA (error: bit 0 host, bit 1 status) clears the masked pending flags. A request in the same cycle as its acknowledge wins, and the flag stays set.
- R11: After reset all enables and pending flags are 0, the vector reads 0 and the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | NUM_CH | Per-channel transmit completion pulses |
| rx_req | input | NUM_CH | Per-channel receive completion pulses |
| host_err | input | 1 | Host error event pulse |
| stat_evt | input | 1 | Status event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| irq_line | output | 1 | Interrupt line to the host |

## Verification
Single-channel pulses in each group check that the vector carries the right flag bit and channel field, and that the flags are sticky. Pulses on several channels, followed by acknowledges one at a time, show whether the lowest-numbered channel is reported first. The enable masks are toggled bit by bit while flags are pending, for channels and for both error sources. This separates gating from pending capture, and shows that the set and clear registers act independently. End-of-interrupt writes are issued both with nothing left pending and with a source still active. Together with an acknowledge that arrives in the same cycle as a new request, these tell line holding, re-arming and the request-over-acknowledge priority apart.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   // Register word addresses
   localparam int A_TX_EN_SET  = 'h0;
   localparam int A_TX_EN_CLR  = 'h1;
   localparam int A_RX_EN_SET  = 'h2;
   localparam int A_RX_EN_CLR  = 'h3;
   localparam int A_ERR_EN_SET = 'h4;
   localparam int A_ERR_EN_CLR = 'h5;
   localparam int A_VECTOR     = 'h6;
   localparam int A_EOI        = 'h7;
   localparam int A_TX_ACK     = 'h8;
   localparam int A_RX_ACK     = 'h9;
   localparam int A_ERR_ACK    = 'hA;
   // Vector word layout
   localparam int V_TX_CH_LSB  = 0;
   localparam int V_RX_CH_LSB  = 8;
   localparam int V_TX_FLAG    = 16;
   localparam int V_RX_FLAG    = 17;
   localparam int V_HOST_FLAG  = 18;
   localparam int V_STAT_FLAG  = 19;
   localparam int V_MIN_WIDTH  = 20;
   // Error source indices
   localparam int E_HOST       = 0;
   localparam int E_STAT       = 1;
   localparam int NUM_ERR      = 2;
endpackage

// File: rtl/irqv_src_bank.sv
module irqv_src_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   input  logic         en_set_we,
   input  logic         en_clr_we,
   input  logic         ack_we,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] en,
   output logic [W-1:0] pend,
   output logic [W-1:0] active
);
   generate
      if (W < 1) begin : g_bad_width
         $error("irqv_src_bank: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] ack_mask;
   assign ack_mask = ack_we ? wmask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= '0;
         pend <= '0;
      end else begin
         if (en_set_we)
            en <= en | wmask;
         else if (en_clr_we)
            en <= en & ~wmask;
         pend <= (pend & ~ack_mask) | req;
      end
   end

   assign active = pend & en;

   p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |=> ((pend & $past(req)) == $past(req)));
   p_en_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr_we && !en_set_we) |=> ((en & $past(wmask)) == '0));
   p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> ((pend & $past(wmask & ~req)) == '0));
endmodule

// File: rtl/irqv_low_first.sv
module irqv_low_first #(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign hit = |vec;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irqv_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tx_req,
   input  logic [NUM_CH-1:0] rx_req,
   input  logic              host_err,
   input  logic              stat_evt,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_line
);
   localparam int CH_W = $clog2(NUM_CH);

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
         $error("irq_vector_ctrl: NUM_CH must be 2..8 to fit the channel field");
      end
      if (DATA_W < V_MIN_WIDTH) begin : g_bad_data
         $error("irq_vector_ctrl: DATA_W too narrow for the vector word");
      end
      if ((1 << ADDR_W) <= A_ERR_ACK) begin : g_bad_addr
         $error("irq_vector_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   // Write decode
   function automatic logic wr_at(input int a);
      return bus_wr && (bus_addr == ADDR_W'(a));
   endfunction

   logic eoi_we;
   assign eoi_we = wr_at(A_EOI);

   logic [NUM_CH-1:0]  tx_en, tx_pend, tx_act;
   logic [NUM_CH-1:0]  rx_en, rx_pend, rx_act;
   logic [NUM_ERR-1:0] err_en, err_pend, err_act, err_req;

   assign err_req[E_HOST] = host_err;
   assign err_req[E_STAT] = stat_evt;

   irqv_src_bank #(.W(NUM_CH)) u_tx_bank (
      .clk(clk), .rst_n(rst_n), .req(tx_req),
      .en_set_we(wr_at(A_TX_EN_SET)), .en_clr_we(wr_at(A_TX_EN_CLR)),
      .ack_we(wr_at(A_TX_ACK)), .wmask(bus_wdata[NUM_CH-1:0]),
      .en(tx_en), .pend(tx_pend), .active(tx_act));

   irqv_src_bank #(.W(NUM_CH)) u_rx_bank (
      .clk(clk), .rst_n(rst_n), .req(rx_req),
      .en_set_we(wr_at(A_RX_EN_SET)), .en_clr_we(wr_at(A_RX_EN_CLR)),
      .ack_we(wr_at(A_RX_ACK)), .wmask(bus_wdata[NUM_CH-1:0]),
      .en(rx_en), .pend(rx_pend), .active(rx_act));

   irqv_src_bank #(.W(NUM_ERR)) u_err_bank (
      .clk(clk), .rst_n(rst_n), .req(err_req),
      .en_set_we(wr_at(A_ERR_EN_SET)), .en_clr_we(wr_at(A_ERR_EN_CLR)),
      .ack_we(wr_at(A_ERR_ACK)), .wmask(bus_wdata[NUM_ERR-1:0]),
      .en(err_en), .pend(err_pend), .active(err_act));

   // Lowest active channel per group
   logic            tx_hit, rx_hit;
   logic [CH_W-1:0] tx_ch, rx_ch;

   irqv_low_first #(.W(NUM_CH), .IW(CH_W)) u_tx_enc (
      .vec(tx_act), .hit(tx_hit), .idx(tx_ch));
   irqv_low_first #(.W(NUM_CH), .IW(CH_W)) u_rx_enc (
      .vec(rx_act), .hit(rx_hit), .idx(rx_ch));

   logic [DATA_W-1:0] vector;
   always_comb begin
      vector = '0;
      vector[V_TX_CH_LSB +: CH_W] = tx_ch;
      vector[V_RX_CH_LSB +: CH_W] = rx_ch;
      vector[V_TX_FLAG]   = tx_hit;
      vector[V_RX_FLAG]   = rx_hit;
      vector[V_HOST_FLAG] = err_act[E_HOST];
      vector[V_STAT_FLAG] = err_act[E_STAT];
   end

   // Read mux
   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         A_TX_EN_SET:  bus_rdata[NUM_CH-1:0]  = tx_en;
         A_RX_EN_SET:  bus_rdata[NUM_CH-1:0]  = rx_en;
         A_ERR_EN_SET: bus_rdata[NUM_ERR-1:0] = err_en;
         A_VECTOR:     bus_rdata = vector;
         default:      bus_rdata = '0;
      endcase
   end

   // Interrupt line: set by any active source, held until end-of-interrupt
   logic any_act;
   assign any_act = (|tx_act) | (|rx_act) | (|err_act);

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_line <= 1'b0;
      else if (eoi_we)
         irq_line <= 1'b0;
      else if (any_act)
         irq_line <= 1'b1;
   end

   p_line_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_line && !eoi_we) |=> irq_line);
   p_line_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (any_act && !eoi_we) |=> irq_line);
   p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_we |=> !irq_line);
   p_tx_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vector[V_TX_FLAG] |-> (tx_act[tx_ch] &&
         ((tx_act & ((NUM_CH'(1) << tx_ch) - NUM_CH'(1))) == '0)));
   p_rx_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vector[V_RX_FLAG] |-> (rx_act[rx_ch] &&
         ((rx_act & ((NUM_CH'(1) << rx_ch) - NUM_CH'(1))) == '0)));
   p_err_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vector[V_HOST_FLAG] |-> (err_pend[E_HOST] && err_en[E_HOST]));
   p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vector[V_TX_FLAG] |-> ((tx_pend & tx_en) != '0));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tx_req = '0;
   logic [7:0]  rx_req = '0;
   logic        host_err = 1'b0;
   logic        stat_evt = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_line;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
      .host_err(host_err), .stat_evt(stat_evt), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_line(irq_line));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input logic [7:0] t, input logic [7:0] r, input logic h, input logic s);
      @(negedge clk);
      tx_req = t; rx_req = r; host_err = h; stat_evt = s;
      @(negedge clk);
      tx_req = '0; rx_req = '0; host_err = 1'b0; stat_evt = 1'b0;
   endtask

   task automatic clean();
      wr('h1, 32'hFF); wr('h3, 32'hFF); wr('h5, 32'h3);
      wr('h8, 32'hFF); wr('h9, 32'hFF); wr('hA, 32'h3);
      wr('h7, 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd('h6, v); chk("R11 vector after reset", v, 32'h0);
      rd('h0, v); chk("R11 tx enable after reset", v, 32'h0);
      rd('h2, v); chk("R11 rx enable after reset", v, 32'h0);
      rd('h4, v); chk("R11 err enable after reset", v, 32'h0);
      chk("R11 line after reset", 32'(irq_line), 32'h0);
      rd('hF, v); chk("R2 undecoded read", v, 32'h0);
   endtask

   task automatic t_enables();
      logic [31:0] v;
      wr('h0, 32'hA5); rd('h0, v); chk("R2 tx set", v, 32'hA5);
      wr('h0, 32'h0F); rd('h0, v); chk("R2 tx set ORs", v, 32'hAF);
      wr('h1, 32'h05); rd('h0, v); chk("R2 tx clear mask", v, 32'hAA);
      wr('h1, 32'hFF); rd('h0, v); chk("R2 tx clear all", v, 32'h00);
      wr('h2, 32'h3C); rd('h2, v); chk("R2 rx set", v, 32'h3C);
      wr('h3, 32'hFF); rd('h2, v); chk("R2 rx clear all", v, 32'h00);
      wr('h4, 32'h2);  rd('h4, v); chk("R2 err set", v, 32'h2);
      wr('h5, 32'h3);  rd('h4, v); chk("R2 err clear", v, 32'h0);
   endtask

   task automatic t_tx_vector();
      logic [31:0] v;
      wr('h0, 32'hFF);
      pulse(8'h20, 8'h0, 1'b0, 1'b0);
      rd('h6, v); chk("R4 tx vector ch5", v, 32'h0001_0005);
      chk("R8 line not yet high", 32'(irq_line), 32'h0);
      @(negedge clk);
      chk("R8 line high next cycle", 32'(irq_line), 32'h1);
      repeat (3) @(negedge clk);
      rd('h6, v); chk("R1 tx flag sticky", v, 32'h0001_0005);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      pulse(8'h84, 8'h0, 1'b0, 1'b0);
      rd('h6, v); chk("R7 lowest of 2,5,7", v, 32'h0001_0002);
      wr('h8, 32'h04); rd('h6, v); chk("R10 ack ch2 exposes ch5", v, 32'h0001_0005);
      wr('h8, 32'h20); rd('h6, v); chk("R7 ch7 last", v, 32'h0001_0007);
      wr('h8, 32'h80); rd('h6, v); chk("R10 all tx acked", v, 32'h0);
   endtask

   task automatic t_rx_vector();
      logic [31:0] v;
      wr('h2, 32'hFF);
      pulse(8'h0, 8'h48, 1'b0, 1'b0);
      rd('h6, v); chk("R5 rx vector ch3", v, 32'h0002_0300);
      pulse(8'h10, 8'h0, 1'b0, 1'b0);
      rd('h6, v); chk("R5 tx and rx together", v, 32'h0003_0304);
      wr('h9, 32'h08); rd('h6, v); chk("R7 rx next ch6", v, 32'h0003_0604);
   endtask

   task automatic t_errors();
      logic [31:0] v;
      clean();
      pulse(8'h0, 8'h0, 1'b1, 1'b0);
      rd('h6, v); chk("R6 host masked", v, 32'h0);
      wr('h4, 32'h1); rd('h6, v); chk("R6 host enabled", v, 32'h0004_0000);
      pulse(8'h0, 8'h0, 1'b0, 1'b1);
      rd('h6, v); chk("R6 status masked", v, 32'h0004_0000);
      wr('h4, 32'h2); rd('h6, v); chk("R6 both flags", v, 32'h000C_0000);
      wr('h5, 32'h1); rd('h6, v); chk("R6 host gated off", v, 32'h0008_0000);
      wr('hA, 32'h3); wr('h4, 32'h3); rd('h6, v); chk("R10 err acked", v, 32'h0);
   endtask

   task automatic t_masking();
      logic [31:0] v;
      clean();
      pulse(8'h02, 8'h0, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      rd('h6, v); chk("R3 disabled not in vector", v, 32'h0);
      chk("R3 disabled no line", 32'(irq_line), 32'h0);
      wr('h0, 32'h02);
      rd('h6, v); chk("R3 enabled later shows", v, 32'h0001_0001);
      @(negedge clk);
      chk("R3 line after late enable", 32'(irq_line), 32'h1);
   endtask

   task automatic t_line_eoi();
      logic [31:0] v;
      wr('h8, 32'h02);
      rd('h6, v); chk("R8 acked vector empty", v, 32'h0);
      repeat (2) @(negedge clk);
      chk("R8 line held until EOI", 32'(irq_line), 32'h1);
      wr('h7, 32'h0);
      chk("R9 EOI drops line", 32'(irq_line), 32'h0);
      @(negedge clk);
      chk("R9 stays low when idle", 32'(irq_line), 32'h0);
      wr('h0, 32'hFF);
      pulse(8'h08, 8'h0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R8 line on new source", 32'(irq_line), 32'h1);
      wr('h7, 32'hDEAD_BEEF);
      chk("R9 EOI any data drops", 32'(irq_line), 32'h0);
      @(negedge clk);
      chk("R9 re-arm when pending", 32'(irq_line), 32'h1);
   endtask

   task automatic t_ack_race();
      logic [31:0] v;
      clean();
      wr('h0, 32'hFF);
      @(negedge clk);
      tx_req = 8'h10; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h10;
      @(negedge clk);
      tx_req = '0; bus_wr = 1'b0;
      rd('h6, v); chk("R10 request beats ack", v, 32'h0001_0004);
      wr('h8, 32'h10); rd('h6, v); chk("R10 later ack clears", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enables();
      t_tx_vector();
      t_priority();
      t_rx_vector();
      t_errors();
      t_masking();
      t_line_eoi();
      t_ack_race();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule